// File: doc/BRIEF.md
# Auto-Precharge Hint Filter

This block sits in front of the command scheduler of one DRAM pseudo-channel. Each incoming request carries a read/write type, a flat address and a user flag that asks for the page to be closed (auto-precharge) after the access. The block splits the address into stack ID, bank group, bank, row and column. Which address bits hold which field depends on one of three run-time orderings and on the access granularity (32-byte or 64-byte). It then forwards the request with the decoded fields and a final auto-precharge bit.

Each request waits in a one-entry lookahead stage until the next request arrives. In hint mode, a held request that asks for precharge has its flag dropped when the next request is of the same type, targets the same page and does not ask for precharge. The page then stays open for that next access. In forced mode the flag passes through untouched. Reads and writes each have their own policy input. A held request that sees no follower within a parameterised number of idle cycles is released with its original flag.

Top module: `ap_hint_filter`

## Requirements
- R1: After reset, `out_valid` is 0 and `in_ready` is 1.
- R2: For a request whose type has hint policy off (`cfg_rd_hint`=0 for reads, `cfg_wr_hint`=0 for writes), `out_ap` equals the `in_ap` given with that request.
- R3: With hint policy on for its type, a held request with flag 1 leaves with `out_ap`=0 when the next accepted request has the same type, the same page (equal stack ID, bank group, bank and row) and flag 0.
- R4: With hint policy on, the flag of a held request is kept when the next request differs in row, in type, or also carries flag 1.
- R5: The read policy and the write policy act independently: hint on reads with forced writes clears only read flags.
- R6: With `cfg_order`=0, the address from MSB to LSB is {stack ID, bank group, bank, row, column slot}.
- R7: With `cfg_order`=1 the address is {stack ID, row, bank, column slot, bank group}; with `cfg_order`=2 it is {row, stack ID, bank, column slot, bank group}.
- R8: The column slot is 5 address bits. With `cfg_gran64`=0 they form column bits 5..1 and `out_col[0]`=0. With `cfg_gran64`=1, `out_col[1:0]`=00 and the lowest address bit is ignored: it is the lowest bit of the slot in ordering 0, and it sits below the bank group in orderings 1 and 2.
- R9: With `cfg_sid_en`=0 (4-high stack), `out_sid` is 0 whatever the address bits in the stack ID position.
- R10: A held request that sees no new input for IDLE_MAX cycles is released with its original flag. Before that it is not presented.
- R11: Requests leave in arrival order with none lost or duplicated. While `out_valid` is 1 and `out_ready` is 0, `in_ready` is 0 and the output stays unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_order | input | 2 | Address field ordering (0, 1, 2) |
| cfg_gran64 | input | 1 | 1 = 64-byte granularity, 0 = 32-byte |
| cfg_sid_en | input | 1 | 1 = stack ID field present (8-high stack) |
| cfg_rd_hint | input | 1 | 1 = hint policy for reads, 0 = forced |
| cfg_wr_hint | input | 1 | 1 = hint policy for writes, 0 = forced |
| in_valid | input | 1 | Request valid |
| in_ready | output | 1 | Request accepted when high with in_valid |
| in_is_wr | input | 1 | 1 = write, 0 = read |
| in_addr | input | SID_W+BG_W+BA_W+ROW_W+5 | Request address |
| in_ap | input | 1 | User auto-precharge request |
| out_valid | output | 1 | Output request valid |
| out_ready | input | 1 | Downstream ready |
| out_is_wr | output | 1 | Request type |
| out_sid | output | SID_W | Decoded stack ID |
| out_bg | output | BG_W | Decoded bank group |
| out_bank | output | BA_W | Decoded bank |
| out_row | output | ROW_W | Decoded row |
| out_col | output | 6 | Decoded column |
| out_ap | output | 1 | Final auto-precharge bit |

## Verification
The bench builds the block with ROW_W=6 and IDLE_MAX=8, keeping SID_W=1 and BG_W=BA_W=2. The narrow row field lets random traffic hit the same page often, so the hint clearing shows up in the stalled burst and not only in hand-made pairs. The short idle limit lets the bench pick its gaps on purpose: gaps of up to four cycles keep a request held, and gaps of 24 cycles force a timeout release. The bench rebuilds each expected address from chosen fields, so the decoder is checked against a composition written the other way round.

// File: rtl/apf_pkg.sv
package apf_pkg;

  typedef enum logic [1:0] {
    ORD_GROUP_HIGH = 2'd0,
    ORD_STACK_TOP  = 2'd1,
    ORD_ROW_TOP    = 2'd2
  } addr_order_e;

  // Column from the 5-bit slot; the low bits are forced by granularity.
  function automatic logic [5:0] col_fill(input logic [4:0] slot, input logic gran64);
    return gran64 ? {slot[4:1], 2'b00} : {slot, 1'b0};
  endfunction

endpackage

// File: rtl/apf_addr_decode.sv
module apf_addr_decode #(
  parameter int SID_W = 1,
  parameter int BG_W  = 2,
  parameter int BA_W  = 2,
  parameter int ROW_W = 14,
  localparam int ADDR_W = SID_W + BG_W + BA_W + ROW_W + 5
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [1:0]        order,
  input  logic              gran64,
  input  logic              sid_en,
  output logic [SID_W-1:0]  sid,
  output logic [BG_W-1:0]   bg,
  output logic [BA_W-1:0]   bank,
  output logic [ROW_W-1:0]  row,
  output logic [5:0]        col
);
  import apf_pkg::*;

  localparam int LOW_W = BG_W + 5;

  logic [LOW_W-1:0]        low;
  logic [ADDR_W-LOW_W-1:0] up;
  logic [4:0]              slot;
  logic [SID_W-1:0]        sid_raw;

  assign low = addr[LOW_W-1:0];
  assign up  = addr[ADDR_W-1:LOW_W];

  always_comb begin
    slot    = '0;
    bg      = '0;
    bank    = '0;
    row     = '0;
    sid_raw = '0;
    if (order == ORD_STACK_TOP || order == ORD_ROW_TOP) begin
      if (gran64) begin
        slot = {low[LOW_W-1:BG_W+1], low[0]};
        bg   = low[BG_W:1];
      end else begin
        slot = low[LOW_W-1:BG_W];
        bg   = low[BG_W-1:0];
      end
      bank = up[BA_W-1:0];
      if (order == ORD_STACK_TOP) begin
        row     = up[BA_W +: ROW_W];
        sid_raw = up[BA_W+ROW_W +: SID_W];
      end else begin
        sid_raw = up[BA_W +: SID_W];
        row     = up[BA_W+SID_W +: ROW_W];
      end
    end else begin
      slot    = addr[4:0];
      row     = addr[5 +: ROW_W];
      bank    = addr[5+ROW_W +: BA_W];
      bg      = addr[5+ROW_W+BA_W +: BG_W];
      sid_raw = addr[ADDR_W-1 -: SID_W];
    end
  end

  assign sid = sid_en ? sid_raw : '0;
  assign col = col_fill(slot, gran64);

endmodule

// File: rtl/apf_hold_stage.sv
module apf_hold_stage #(
  parameter int PW       = 8,
  parameter int IDLE_MAX = 64,
  localparam int CW = $clog2(IDLE_MAX + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [PW-1:0] in_data,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [PW-1:0] held_data,
  output logic          tmo_evt
);
  logic          h_valid;
  logic [CW-1:0] idle_cnt;
  logic          take, give;

  assign tmo_evt   = h_valid && (idle_cnt == CW'(IDLE_MAX));
  assign out_valid = h_valid && (in_valid || tmo_evt);
  assign in_ready  = !h_valid || out_ready;
  assign take      = in_valid && in_ready;
  assign give      = out_valid && out_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      h_valid  <= 1'b0;
      idle_cnt <= '0;
      held_data <= '0;
    end else if (take) begin
      h_valid   <= 1'b1;
      held_data <= in_data;
      idle_cnt  <= '0;
    end else if (give) begin
      h_valid  <= 1'b0;
      idle_cnt <= '0;
    end else if (h_valid && !in_valid && !tmo_evt) begin
      idle_cnt <= idle_cnt + 1'b1;
    end
  end

endmodule

// File: rtl/apf_lookahead_policy.sv
module apf_lookahead_policy #(
  parameter int PG_W = 8
) (
  input  logic [PG_W-1:0] held_page,
  input  logic            held_wr,
  input  logic            held_ap,
  input  logic [PG_W-1:0] nxt_page,
  input  logic            nxt_wr,
  input  logic            nxt_ap,
  input  logic            nxt_valid,
  input  logic            tmo_evt,
  input  logic            rd_hint,
  input  logic            wr_hint,
  output logic            fin_ap,
  output logic            clear_evt
);
  function automatic logic keeps_page_open(
    input logic [PG_W-1:0] a_page, input logic a_wr, input logic a_ap,
    input logic [PG_W-1:0] b_page, input logic b_wr, input logic b_ap);
    return a_ap && !b_ap && (a_wr == b_wr) && (a_page == b_page);
  endfunction

  logic hint_on;
  assign hint_on   = held_wr ? wr_hint : rd_hint;
  assign clear_evt = hint_on && nxt_valid && !tmo_evt &&
                     keeps_page_open(held_page, held_wr, held_ap, nxt_page, nxt_wr, nxt_ap);
  assign fin_ap    = held_ap && !clear_evt;

endmodule

// File: rtl/ap_hint_filter.sv
module ap_hint_filter #(
  parameter int SID_W    = 1,
  parameter int BG_W     = 2,
  parameter int BA_W     = 2,
  parameter int ROW_W    = 14,
  parameter int IDLE_MAX = 64,
  localparam int ADDR_W = SID_W + BG_W + BA_W + ROW_W + 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        cfg_order,
  input  logic              cfg_gran64,
  input  logic              cfg_sid_en,
  input  logic              cfg_rd_hint,
  input  logic              cfg_wr_hint,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic              in_is_wr,
  input  logic [ADDR_W-1:0] in_addr,
  input  logic              in_ap,
  output logic              out_valid,
  input  logic              out_ready,
  output logic              out_is_wr,
  output logic [SID_W-1:0]  out_sid,
  output logic [BG_W-1:0]   out_bg,
  output logic [BA_W-1:0]   out_bank,
  output logic [ROW_W-1:0]  out_row,
  output logic [5:0]        out_col,
  output logic              out_ap
);
  localparam int PG_W = SID_W + BG_W + BA_W + ROW_W;
  localparam int PW   = PG_W + 8;

  typedef struct packed {
    logic             wr;
    logic [SID_W-1:0] sid;
    logic [BG_W-1:0]  bg;
    logic [BA_W-1:0]  bank;
    logic [ROW_W-1:0] row;
    logic [5:0]       col;
    logic             ap;
  } req_t;

  req_t          in_req, held_req;
  logic [PW-1:0] held_vec;
  logic          tmo_evt, hint_clear, held_ap, fin_ap;

  apf_addr_decode #(
    .SID_W(SID_W), .BG_W(BG_W), .BA_W(BA_W), .ROW_W(ROW_W)
  ) u_dec (
    .addr(in_addr), .order(cfg_order), .gran64(cfg_gran64), .sid_en(cfg_sid_en),
    .sid(in_req.sid), .bg(in_req.bg), .bank(in_req.bank), .row(in_req.row), .col(in_req.col)
  );

  assign in_req.wr = in_is_wr;
  assign in_req.ap = in_ap;

  apf_hold_stage #(.PW(PW), .IDLE_MAX(IDLE_MAX)) u_hold (
    .clk(clk), .rst_n(rst_n),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_req),
    .out_valid(out_valid), .out_ready(out_ready),
    .held_data(held_vec), .tmo_evt(tmo_evt)
  );

  assign held_req = req_t'(held_vec);
  assign held_ap  = held_req.ap;

  apf_lookahead_policy #(.PG_W(PG_W)) u_pol (
    .held_page({held_req.sid, held_req.bg, held_req.bank, held_req.row}),
    .held_wr(held_req.wr), .held_ap(held_ap),
    .nxt_page({in_req.sid, in_req.bg, in_req.bank, in_req.row}),
    .nxt_wr(in_req.wr), .nxt_ap(in_req.ap), .nxt_valid(in_valid),
    .tmo_evt(tmo_evt), .rd_hint(cfg_rd_hint), .wr_hint(cfg_wr_hint),
    .fin_ap(fin_ap), .clear_evt(hint_clear)
  );

  assign out_is_wr = held_req.wr;
  assign out_sid   = held_req.sid;
  assign out_bg    = held_req.bg;
  assign out_bank  = held_req.bank;
  assign out_row   = held_req.row;
  assign out_col   = held_req.col;
  assign out_ap    = fin_ap;

endmodule

// File: rtl/apf_checker.sv
module apf_checker #(
  parameter int PW    = 8,
  parameter int SID_W = 1
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_ready,
  input logic             out_valid,
  input logic             out_ready,
  input logic             out_is_wr,
  input logic             out_ap,
  input logic [5:0]       out_col,
  input logic [SID_W-1:0] out_sid,
  input logic [PW-1:0]    out_pkt,
  input logic             held_ap,
  input logic             tmo_evt,
  input logic             cfg_rd_hint,
  input logic             cfg_wr_hint,
  input logic             cfg_gran64,
  input logic             cfg_sid_en,
  input logic             in_valid
);
  p_idle_after_reset_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (!out_valid && in_ready));

  p_forced_passes_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !(out_is_wr ? cfg_wr_hint : cfg_rd_hint)) |-> (out_ap == held_ap));

  p_clear_only_on_follower_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && (out_ap != held_ap)) |-> (held_ap && !out_ap && in_valid && !tmo_evt));

  p_col_grain_r8: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (!out_col[0] && (!cfg_gran64 || !out_col[1])));

  p_sid_absent_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !cfg_sid_en) |-> (out_sid == '0));

  p_timeout_presents_r10: assert property (@(posedge clk) disable iff (!rst_n)
    tmo_evt |-> (out_valid && (out_ap == held_ap)));

  p_stall_stable_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_pkt) && $stable(out_ap)));

  p_stall_blocks_input_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |-> !in_ready);

endmodule

bind ap_hint_filter apf_checker #(.PW(PW), .SID_W(SID_W)) u_apf_chk (
  .clk(clk), .rst_n(rst_n), .in_ready(in_ready), .out_valid(out_valid),
  .out_ready(out_ready), .out_is_wr(out_is_wr), .out_ap(out_ap), .out_col(out_col),
  .out_sid(out_sid), .out_pkt(held_vec), .held_ap(held_ap), .tmo_evt(tmo_evt),
  .cfg_rd_hint(cfg_rd_hint), .cfg_wr_hint(cfg_wr_hint), .cfg_gran64(cfg_gran64),
  .cfg_sid_en(cfg_sid_en), .in_valid(in_valid)
);

// File: tb/ap_hint_filter_test.sv
`timescale 1ns/100ps
module ap_hint_filter_test;
  localparam int SID_W = 1, BG_W = 2, BA_W = 2, ROW_W = 6, IDLE_MAX = 8;
  localparam int ADDR_W = SID_W + BG_W + BA_W + ROW_W + 5;
  localparam int LONG = 3 * IDLE_MAX;

  typedef logic [18:0] item_t; // {wr, sid, bg[1:0], ba[1:0], row[5:0], col[5:0], ap}

  logic clk = 1'b0, rst_n = 1'b0;
  logic [1:0] cfg_order = 2'd0;
  logic cfg_gran64 = 1'b0, cfg_sid_en = 1'b1, cfg_rd_hint = 1'b0, cfg_wr_hint = 1'b0;
  logic in_valid = 1'b0, in_is_wr = 1'b0, in_ap = 1'b0;
  logic [ADDR_W-1:0] in_addr = '0;
  logic in_ready, out_valid, out_is_wr, out_ap;
  logic out_ready = 1'b1;
  logic [SID_W-1:0] out_sid;
  logic [BG_W-1:0] out_bg;
  logic [BA_W-1:0] out_bank;
  logic [ROW_W-1:0] out_row;
  logic [5:0] out_col;

  always #2.5 clk = ~clk;

  ap_hint_filter #(.SID_W(SID_W), .BG_W(BG_W), .BA_W(BA_W), .ROW_W(ROW_W), .IDLE_MAX(IDLE_MAX)) uut (
    .clk(clk), .rst_n(rst_n), .cfg_order(cfg_order), .cfg_gran64(cfg_gran64),
    .cfg_sid_en(cfg_sid_en), .cfg_rd_hint(cfg_rd_hint), .cfg_wr_hint(cfg_wr_hint),
    .in_valid(in_valid), .in_ready(in_ready), .in_is_wr(in_is_wr), .in_addr(in_addr),
    .in_ap(in_ap), .out_valid(out_valid), .out_ready(out_ready), .out_is_wr(out_is_wr),
    .out_sid(out_sid), .out_bg(out_bg), .out_bank(out_bank), .out_row(out_row),
    .out_col(out_col), .out_ap(out_ap)
  );

  int n_checks = 0, n_fail = 0, n_sent = 0, n_out = 0, cyc = 0;
  bit stall_en = 1'b0, done = 1'b0;
  item_t expq[$];
  string tagq[$];
  bit p_have = 1'b0;
  item_t p_item;
  string p_tag;

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", tag, what, act, exp);
    end
  endtask

  // Output ready: steady, or low one cycle in three while stalling.
  always @(negedge clk) begin
    cyc <= cyc + 1;
    out_ready <= stall_en ? ((cyc % 3) != 0) : 1'b1;
  end

  // Monitor: compare each transfer with the scoreboard head.
  always @(negedge clk) begin
    #2;
    if (rst_n && out_valid && out_ready) begin
      n_out++;
      if (expq.size() == 0) begin
        check(1'b0, "R11", "unexpected output", 32'(n_out), 32'(n_sent));
      end else begin
        item_t e, a;
        string t;
        e = expq.pop_front();
        t = tagq.pop_front();
        a = {out_is_wr, out_sid, out_bg, out_bank, out_row, out_col, out_ap};
        check(a == e, t, "output item", 32'(a), 32'(e));
      end
    end
  end

  // Address built from fields, in the layout each ordering describes.
  function automatic logic [ADDR_W-1:0] compose(input logic sid, input logic [1:0] bg,
      input logic [1:0] ba, input logic [5:0] row, input logic [5:0] col, input logic x);
    logic [4:0] s;
    s = cfg_gran64 ? {col[5:2], x} : col[5:1];
    case (cfg_order)
      2'd1: return cfg_gran64 ? {sid, row, ba, col[5:2], bg, x} : {sid, row, ba, s, bg};
      2'd2: return cfg_gran64 ? {row, sid, ba, col[5:2], bg, x} : {row, sid, ba, s, bg};
      default: return {sid, bg, ba, row, s};
    endcase
  endfunction

  function automatic item_t expect_item(input logic wr, input logic sid, input logic [1:0] bg,
      input logic [1:0] ba, input logic [5:0] row, input logic [5:0] col, input logic ap);
    logic [5:0] c;
    c = cfg_gran64 ? (col & 6'b111100) : (col & 6'b111110);
    return {wr, cfg_sid_en ? sid : 1'b0, bg, ba, row, c, ap};
  endfunction

  task automatic push_prev(input bit cleared);
    if (p_have) begin
      item_t it;
      it = p_item;
      if (cleared) it[0] = 1'b0;
      expq.push_back(it);
      tagq.push_back(p_tag);
      p_have = 1'b0;
    end
  endtask

  task automatic send(input logic wr, input logic sid, input logic [1:0] bg, input logic [1:0] ba,
                      input logic [5:0] row, input logic [5:0] col, input logic ap,
                      input int gap, input string tag);
    item_t it;
    logic x;
    it = expect_item(wr, sid, bg, ba, row, col, ap);
    x = 1'($urandom());
    if (p_have) begin
      bit hint, clr;
      hint = p_item[18] ? cfg_wr_hint : cfg_rd_hint;
      clr = (gap < IDLE_MAX) && hint && p_item[0] && !it[0] &&
            (p_item[18] == it[18]) && (p_item[17:7] == it[17:7]);
      push_prev(clr);
    end
    repeat (gap) @(negedge clk);
    in_valid = 1'b1; in_is_wr = wr; in_ap = ap;
    in_addr = compose(sid, bg, ba, row, col, x);
    #1;
    while (!in_ready) begin @(negedge clk); #1; end
    @(negedge clk);
    in_valid = 1'b0;
    n_sent++;
    p_have = 1'b1; p_item = it; p_tag = tag;
  endtask

  task automatic flush(input int wait_cycles);
    push_prev(1'b0);
    repeat (wait_cycles) @(negedge clk);
  endtask

  task automatic set_cfg(input logic [1:0] ord, input logic g64, input logic sen,
                         input logic rh, input logic wh);
    cfg_order = ord; cfg_gran64 = g64; cfg_sid_en = sen; cfg_rd_hint = rh; cfg_wr_hint = wh;
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    #1;
    // R1: idle after reset
    check(out_valid == 1'b0, "R1", "out_valid after reset", 32'(out_valid), 0);
    check(in_ready == 1'b1, "R1", "in_ready after reset", 32'(in_ready), 1);
    @(negedge clk);

    // R6: group-high ordering, 32-byte
    set_cfg(2'd0, 1'b0, 1'b1, 1'b0, 1'b0);
    send(0, 1, 2'd2, 2'd1, 6'h2d, 6'h3e, 1, 0, "R6");
    send(1, 0, 2'd1, 2'd3, 6'h12, 6'h15, 0, 2, "R6");
    send(0, 1, 2'd3, 2'd0, 6'h3f, 6'h2a, 1, LONG, "R6");
    flush(LONG);

    // R7: the two bank-group-low orderings
    set_cfg(2'd1, 1'b0, 1'b1, 1'b0, 1'b0);
    send(0, 1, 2'd1, 2'd2, 6'h21, 6'h1b, 0, 0, "R7");
    send(1, 0, 2'd3, 2'd1, 6'h0c, 6'h37, 1, 1, "R7");
    flush(LONG);
    set_cfg(2'd2, 1'b0, 1'b1, 1'b0, 1'b0);
    send(0, 1, 2'd2, 2'd3, 6'h19, 6'h09, 1, 0, "R7");
    send(1, 0, 2'd0, 2'd2, 6'h33, 6'h3c, 0, 3, "R7");
    flush(LONG);

    // R8: 64-byte granularity on all orderings
    for (int o = 0; o < 3; o++) begin
      set_cfg(2'(o), 1'b1, 1'b1, 1'b0, 1'b0);
      send(0, 1, 2'd1, 2'd2, 6'h2b, 6'h3f, 1, 0, "R8");
      send(1, 0, 2'd2, 2'd1, 6'h14, 6'h17, 0, 1, "R8");
      flush(LONG);
    end

    // R9: no stack ID field
    set_cfg(2'd1, 1'b0, 1'b0, 1'b0, 1'b0);
    send(0, 1, 2'd3, 2'd3, 6'h3a, 6'h22, 0, 0, "R9");
    send(1, 1, 2'd0, 2'd1, 6'h05, 6'h11, 1, 0, "R9");
    flush(LONG);

    // R2: forced keeps flag even before a same-page follower
    set_cfg(2'd0, 1'b0, 1'b1, 1'b0, 1'b0);
    send(0, 1, 2'd1, 2'd1, 6'h10, 6'h04, 1, 0, "R2");
    send(0, 1, 2'd1, 2'd1, 6'h10, 6'h08, 0, 0, "R2");
    send(1, 0, 2'd2, 2'd0, 6'h20, 6'h04, 1, 2, "R2");
    send(1, 0, 2'd2, 2'd0, 6'h20, 6'h0c, 0, 1, "R2");
    flush(LONG);

    // R3: hint clears for same type, same page, follower without flag
    set_cfg(2'd0, 1'b0, 1'b1, 1'b1, 1'b1);
    send(0, 1, 2'd2, 2'd3, 6'h2e, 6'h04, 1, 0, "R3");
    send(0, 1, 2'd2, 2'd3, 6'h2e, 6'h20, 0, 0, "R3");
    send(1, 0, 2'd0, 2'd1, 6'h07, 6'h02, 1, 2, "R3");
    send(1, 0, 2'd0, 2'd1, 6'h07, 6'h12, 0, 0, "R3");
    flush(LONG);

    // R4: hint keeps flag for other row, other type, flagged follower
    send(0, 1, 2'd2, 2'd3, 6'h2e, 6'h04, 1, 0, "R4");
    send(0, 1, 2'd2, 2'd3, 6'h2f, 6'h04, 0, 0, "R4");
    send(0, 0, 2'd1, 2'd0, 6'h11, 6'h04, 1, 0, "R4");
    send(1, 0, 2'd1, 2'd0, 6'h11, 6'h04, 0, 0, "R4");
    send(1, 0, 2'd1, 2'd0, 6'h11, 6'h06, 1, 0, "R4");
    send(1, 0, 2'd1, 2'd0, 6'h11, 6'h08, 1, 1, "R4");
    flush(LONG);

    // R5: reads hinted, writes forced
    set_cfg(2'd0, 1'b0, 1'b1, 1'b1, 1'b0);
    send(1, 1, 2'd3, 2'd2, 6'h09, 6'h04, 1, 0, "R5");
    send(1, 1, 2'd3, 2'd2, 6'h09, 6'h08, 0, 0, "R5");
    send(0, 1, 2'd3, 2'd2, 6'h09, 6'h04, 1, 0, "R5");
    send(0, 1, 2'd3, 2'd2, 6'h09, 6'h08, 0, 0, "R5");
    flush(LONG);

    // R10: timeout release with original flag, nothing presented before
    set_cfg(2'd0, 1'b0, 1'b1, 1'b1, 1'b1);
    send(0, 0, 2'd1, 2'd1, 6'h01, 6'h02, 1, 0, "R10");
    flush(4);
    #2;
    check(out_valid == 1'b0, "R10", "held item presented early", 32'(out_valid), 0);
    repeat (IDLE_MAX) @(negedge clk);
    #3;
    check(expq.size() == 0, "R10", "item not released on timeout", 32'(expq.size()), 0);
    @(negedge clk);
    send(0, 0, 2'd1, 2'd1, 6'h01, 6'h02, 1, 0, "R10");
    send(0, 0, 2'd1, 2'd1, 6'h01, 6'h06, 0, LONG, "R10");
    flush(LONG);

    // R11: stalled burst with frequent page hits
    stall_en = 1'b1;
    for (int i = 0; i < 40; i++) begin
      send(1'($urandom()), 1'($urandom()), 2'($urandom() % 2), 2'($urandom() % 2),
           6'($urandom() % 2), 6'($urandom()), 1'($urandom()), int'($urandom() % 3), "R11");
    end
    flush(LONG);
    stall_en = 1'b0;
    repeat (4) @(negedge clk);
    check(expq.size() == 0, "R11", "items left in scoreboard", 32'(expq.size()), 0);
    check(n_out == n_sent, "R11", "output count", 32'(n_out), 32'(n_sent));

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
    end
  end

endmodule